// File: doc/BRIEF.md
# ADC Calibration Control Sequencer

This block is the digital control for the calibration phase of a sigma-delta converter. It watches a calibration request strobe. A request counts only after the strobe has been seen high for a minimum number of clock cycles and has then gone low. When the strobe rises, the block captures a two-bit mode code. When a valid request ends, it runs a timed calibration step whose length depends on that code. The data-ready flag is held high for the whole step.

The block enforces the ordering of the two-step system calibration: an offset step must come before a gain step. A gain request with no valid offset result is rejected and sets a sticky error. When a step finishes, the block loads the fixed result word for a system step and pulses a load strobe. It also raises a calibrated flag once a full calibration has completed.

The polarity select is not latched. Any change on it cancels the current calibration and any pending offset result. Step lengths are parameters, so a bench can run with short steps.

Top module: `cal_seq_top`

## Requirements
- R1: After reset, dataReady, resultLoad, calibrated and orderErr are 0 and resultWord is all zeros.
- R2: A request is accepted only if calReq, after its two-flop synchronizer, was high for at least MIN_HIGH (default 4) clock cycles before returning low. A shorter pulse is discarded and dataReady stays low.
- R3: The mode code is {modeSel1, modeSel2}: 00 self, 11 system offset, 01 system gain, 10 single-step system. An accepted request raises dataReady on the third rising clock edge after calReq is driven low. dataReady then stays high for exactly the step length of its mode: LEN_SELF, LEN_OFS, LEN_GAIN or LEN_ONE cycles.
- R4: The mode code is captured when the synchronized calReq rises. Changes on modeSel1/modeSel2 after that have no effect on the step.
- R5: A request is dropped if a step is still running at its acceptance edge, which is the third rising edge after calReq goes low. This includes the edge on which the running step finishes.
- R6: When an 11 or 10 step ends, resultLoad pulses for one cycle in the first cycle that dataReady is low, and resultWord becomes all zeros. When a 01 step ends, resultWord becomes all ones with the same pulse. When a 00 step ends, there is no pulse and resultWord is unchanged. resultWord changes only with a pulse.
- R7: A gain (01) request is rejected if no valid offset step has completed since reset, the last polarity change or the last step start. A rejected request starts no step and sets orderErr, which stays set until reset.
- R8: calibrated is cleared by reset and whenever a step starts. It is set when a 00, 10 or 01 step completes. A completed 11 step leaves it at 0.
- R9: Any change on bipolarSel clears calibrated and the pending offset result by the next cycle. A step running during the change still runs its full length and loads its word, but sets neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calReq | input | 1 | Calibration request strobe (asynchronous) |
| modeSel1 | input | 1 | Mode code, upper bit |
| modeSel2 | input | 1 | Mode code, lower bit |
| bipolarSel | input | 1 | Polarity select, not latched |
| dataReady | output | 1 | High while a calibration step runs |
| resultWord | output | RES_W | Result word loaded at step end |
| resultLoad | output | 1 | One-cycle strobe when resultWord is loaded |
| calibrated | output | 1 | A complete calibration is valid |
| orderErr | output | 1 | Sticky error: gain step requested without an offset step |

## Verification
The end of a running step and the acceptance edge of a new request can fall on the same clock edge. The design must drop the request on that edge, even though dataReady is falling at that moment. The bench provokes this by starting an offset step and then releasing a new request at each position across the last several cycles of the step. For each position it computes from R3 and R5 whether the acceptance edge lands on or before the finishing edge, and then counts the steps that follow to judge whether exactly the expected number began.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SELF = 2'b00,
    MODE_GAIN = 2'b01,
    MODE_ONE  = 2'b10,
    MODE_OFS  = 2'b11
  } calMode_e;

  typedef struct packed {
    logic     startStep;
    logic     finishStep;
    calMode_e stepMode;
  } ctrlStrb_t;

endpackage

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
#(
  parameter int MIN_HIGH = 4,
  parameter int SYNC_N   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calReq,
  input  logic [1:0] modeIn,
  input  logic       bipolarSel,
  input  logic       cntZero,
  output ctrlStrb_t  strb,
  output logic       busy,
  output logic       calibrated,
  output logic       orderErr
);

  localparam int HC_W = $clog2(MIN_HIGH + 1);

  logic [SYNC_N-1:0] calSyncVec;
  logic              calSync, calPrev;
  logic [HC_W-1:0]   highCnt;
  calMode_e          reqMode, stepMode;
  logic              offsetDone, spoiled, bpPrev;
  logic              calRise, calFall, reqOk, gainBlocked;
  logic              startStep, finishStep, polChg;

  assign calSync     = calSyncVec[SYNC_N-1];
  assign calRise     = calSync & ~calPrev;
  assign calFall     = ~calSync & calPrev;
  assign reqOk       = calFall && (highCnt >= HC_W'(MIN_HIGH)) && !busy;
  assign gainBlocked = (reqMode == MODE_GAIN) && !offsetDone;
  assign startStep   = reqOk && !gainBlocked;
  assign finishStep  = busy && cntZero;
  assign polChg      = bipolarSel != bpPrev;

  always_comb begin
    strb.startStep  = startStep;
    strb.finishStep = finishStep;
    strb.stepMode   = startStep ? reqMode : stepMode;
  end

  // request conditioning: synchronizer, width count, mode capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calSyncVec <= '0;
      calPrev    <= 1'b0;
      highCnt    <= '0;
      reqMode    <= MODE_SELF;
    end else begin
      calSyncVec <= {calSyncVec[SYNC_N-2:0], calReq};
      calPrev    <= calSync;
      if (calRise) begin
        highCnt <= HC_W'(1);
        reqMode <= calMode_e'(modeIn);
      end else if (calSync && (highCnt < HC_W'(MIN_HIGH))) begin
        highCnt <= highCnt + HC_W'(1);
      end
    end
  end

  // step sequencing and calibration state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      stepMode   <= MODE_SELF;
      offsetDone <= 1'b0;
      spoiled    <= 1'b0;
      calibrated <= 1'b0;
      orderErr   <= 1'b0;
      bpPrev     <= 1'b0;
    end else begin
      bpPrev <= bipolarSel;
      if (reqOk && gainBlocked) orderErr <= 1'b1;

      if (startStep) begin
        busy     <= 1'b1;
        stepMode <= reqMode;
      end else if (finishStep) begin
        busy <= 1'b0;
      end

      if (polChg)         spoiled <= 1'b1;
      else if (startStep) spoiled <= 1'b0;

      if (polChg)
        offsetDone <= 1'b0;
      else if (startStep)
        offsetDone <= 1'b0;
      else if (finishStep && !spoiled && stepMode == MODE_OFS)
        offsetDone <= 1'b1;

      if (polChg)
        calibrated <= 1'b0;
      else if (startStep)
        calibrated <= 1'b0;
      else if (finishStep && !spoiled && stepMode != MODE_OFS)
        calibrated <= 1'b1;
    end
  end

endmodule

// File: rtl/cal_seq_dp.sv
module cal_seq_dp
  import cal_seq_pkg::*;
#(
  parameter int RES_W    = 20,
  parameter int LEN_SELF = 3145655,
  parameter int LEN_OFS  = 1052599,
  parameter int LEN_GAIN = 1068813,
  parameter int LEN_ONE  = 2117389
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  output logic             cntZero,
  output logic [RES_W-1:0] resultWord,
  output logic             resultLoad
);

  localparam int LEN_A   = (LEN_SELF > LEN_OFS) ? LEN_SELF : LEN_OFS;
  localparam int LEN_B   = (LEN_GAIN > LEN_ONE) ? LEN_GAIN : LEN_ONE;
  localparam int LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  logic [CNT_W-1:0] stepCnt;

  function automatic logic [CNT_W-1:0] stepLast(calMode_e m);
    case (m)
      MODE_OFS:  return CNT_W'(LEN_OFS - 1);
      MODE_GAIN: return CNT_W'(LEN_GAIN - 1);
      MODE_ONE:  return CNT_W'(LEN_ONE - 1);
      default:   return CNT_W'(LEN_SELF - 1);
    endcase
  endfunction

  assign cntZero = stepCnt == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt    <= '0;
      resultWord <= '0;
      resultLoad <= 1'b0;
    end else begin
      if (strb.startStep)  stepCnt <= stepLast(strb.stepMode);
      else if (!cntZero)   stepCnt <= stepCnt - CNT_W'(1);

      resultLoad <= strb.finishStep && (strb.stepMode != MODE_SELF);
      if (strb.finishStep) begin
        case (strb.stepMode)
          MODE_OFS, MODE_ONE: resultWord <= '0;
          MODE_GAIN:          resultWord <= '1;
          default:            resultWord <= resultWord;
        endcase
      end
    end
  end

endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
  import cal_seq_pkg::*;
#(
  parameter int RES_W    = 20,
  parameter int LEN_SELF = 3145655,
  parameter int LEN_OFS  = 1052599,
  parameter int LEN_GAIN = 1068813,
  parameter int LEN_ONE  = 2117389,
  parameter int MIN_HIGH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             calReq,
  input  logic             modeSel1,
  input  logic             modeSel2,
  input  logic             bipolarSel,
  output logic             dataReady,
  output logic [RES_W-1:0] resultWord,
  output logic             resultLoad,
  output logic             calibrated,
  output logic             orderErr
);

  ctrlStrb_t strb;
  logic      cntZero;

  cal_seq_ctrl #(.MIN_HIGH(MIN_HIGH), .SYNC_N(2)) ctrl_i (
    .clk(clk), .rstN(rstN), .calReq(calReq), .modeIn({modeSel1, modeSel2}),
    .bipolarSel(bipolarSel), .cntZero(cntZero), .strb(strb), .busy(dataReady),
    .calibrated(calibrated), .orderErr(orderErr)
  );

  cal_seq_dp #(
    .RES_W(RES_W), .LEN_SELF(LEN_SELF), .LEN_OFS(LEN_OFS),
    .LEN_GAIN(LEN_GAIN), .LEN_ONE(LEN_ONE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cntZero(cntZero),
    .resultWord(resultWord), .resultLoad(resultLoad)
  );

endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
  parameter int RES_W    = 20,
  parameter int LEN_SELF = 3145655,
  parameter int LEN_OFS  = 1052599,
  parameter int LEN_GAIN = 1068813,
  parameter int LEN_ONE  = 2117389
) (
  input logic             clk,
  input logic             rstN,
  input logic             bipolarSel,
  input logic             dataReady,
  input logic [RES_W-1:0] resultWord,
  input logic             resultLoad,
  input logic             calibrated,
  input logic             orderErr
);

  int runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else       runLen <= dataReady ? runLen + 1 : 0;
  end

  p_step_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!dataReady && $past(dataReady)) |->
      (runLen == LEN_SELF || runLen == LEN_OFS || runLen == LEN_GAIN || runLen == LEN_ONE));

  p_load_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    resultLoad |-> ($past(dataReady) && !dataReady));

  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !resultLoad |-> $stable(resultWord));

  p_load_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    resultLoad |-> (resultWord == '0 || resultWord == '1));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    orderErr |=> orderErr);

  p_not_cal_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> !calibrated);

  p_cal_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calibrated) |-> ($past(dataReady) && !dataReady));

  p_pol_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bipolarSel != $past(bipolarSel)) |=> !calibrated);

endmodule

bind cal_seq_top cal_seq_chk #(
  .RES_W(RES_W), .LEN_SELF(LEN_SELF), .LEN_OFS(LEN_OFS),
  .LEN_GAIN(LEN_GAIN), .LEN_ONE(LEN_ONE)
) chk_i (
  .clk(clk), .rstN(rstN), .bipolarSel(bipolarSel), .dataReady(dataReady),
  .resultWord(resultWord), .resultLoad(resultLoad), .calibrated(calibrated),
  .orderErr(orderErr)
);

// File: tb/cal_seq_top_tb_top.sv
`timescale 1ns/1ps
module cal_seq_top_tb_top;

  localparam int W        = 8;
  localparam int LEN_SELF = 40;
  localparam int LEN_OFS  = 20;
  localparam int LEN_GAIN = 24;
  localparam int LEN_ONE  = 30;

  logic clk = 1'b0;
  logic rstN, calReq, modeSel1, modeSel2, bipolarSel;
  logic dataReady, resultLoad, calibrated, orderErr;
  logic [W-1:0] resultWord;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  cal_seq_top #(
    .RES_W(W), .LEN_SELF(LEN_SELF), .LEN_OFS(LEN_OFS),
    .LEN_GAIN(LEN_GAIN), .LEN_ONE(LEN_ONE), .MIN_HIGH(4)
  ) dut_i (
    .clk(clk), .rstN(rstN), .calReq(calReq), .modeSel1(modeSel1),
    .modeSel2(modeSel2), .bipolarSel(bipolarSel), .dataReady(dataReady),
    .resultWord(resultWord), .resultLoad(resultLoad), .calibrated(calibrated),
    .orderErr(orderErr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseCal(input logic [1:0] m, input int n);
    {modeSel1, modeSel2} = m;
    calReq = 1'b1;
    tick(n);
    calReq = 1'b0;
  endtask

  // called right after calReq is released, at a falling edge
  task automatic measure(output int lat, output int len, output logic ld,
                         output logic [W-1:0] wd);
    lat = 0; len = 0; ld = 1'b0; wd = resultWord;
    for (int i = 1; i <= 8; i++) begin
      tick(1);
      if (dataReady) begin lat = i; break; end
    end
    if (lat != 0) begin
      len = 1;
      for (int g = 0; g < 10000; g++) begin
        tick(1);
        if (!dataReady) begin ld = resultLoad; wd = resultWord; break; end
        len++;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int lat, len, tot, rises;
    logic ld, prev;
    logic [W-1:0] wd;
    rstN = 1'b0; calReq = 1'b0; modeSel1 = 1'b0; modeSel2 = 1'b0; bipolarSel = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    chkEq("R1 dataReady", int'(dataReady), 0);
    chkEq("R1 resultLoad", int'(resultLoad), 0);
    chkEq("R1 calibrated", int'(calibrated), 0);
    chkEq("R1 orderErr", int'(orderErr), 0);
    chkEq("R1 resultWord", int'(resultWord), 0);

    // R7: gain with no offset since reset
    pulseCal(2'b01, 4); measure(lat, len, ld, wd);
    chkEq("R7 gain rejected start", lat, 0);
    chkEq("R7 orderErr set", int'(orderErr), 1);

    // R3 / R6 / R8 per mode
    pulseCal(2'b11, 4); measure(lat, len, ld, wd);
    chkEq("R3 offset latency", lat, 3);
    chkEq("R3 offset length", len, LEN_OFS);
    chkEq("R6 offset load", int'(ld), 1);
    chkEq("R6 offset word", int'(wd), 0);
    chkEq("R8 offset alone not calibrated", int'(calibrated), 0);

    pulseCal(2'b01, 4); measure(lat, len, ld, wd);
    chkEq("R3 gain length", len, LEN_GAIN);
    chkEq("R6 gain load", int'(ld), 1);
    chkEq("R6 gain word", int'(wd), 255);
    chkEq("R8 gain calibrated", int'(calibrated), 1);
    chkEq("R7 orderErr sticky", int'(orderErr), 1);

    pulseCal(2'b00, 4); measure(lat, len, ld, wd);
    chkEq("R3 self length", len, LEN_SELF);
    chkEq("R6 self no load", int'(ld), 0);
    chkEq("R6 self word kept", int'(wd), 255);
    chkEq("R8 self calibrated", int'(calibrated), 1);

    pulseCal(2'b10, 4); measure(lat, len, ld, wd);
    chkEq("R3 single length", len, LEN_ONE);
    chkEq("R6 single load", int'(ld), 1);
    chkEq("R6 single word", int'(wd), 0);
    tick(1);
    chkEq("R6 load one cycle", int'(resultLoad), 0);

    // R2: pulse width sweep
    for (int n = 1; n <= 6; n++) begin
      pulseCal(2'b10, n); measure(lat, len, ld, wd);
      chkEq($sformatf("R2 width %0d latency", n), lat, (n >= 4) ? 3 : 0);
      chkEq($sformatf("R2 width %0d length", n), len, (n >= 4) ? LEN_ONE : 0);
    end

    // R4: mode changes after the capture point
    {modeSel1, modeSel2} = 2'b11; calReq = 1'b1;
    tick(4); {modeSel1, modeSel2} = 2'b00; tick(2); calReq = 1'b0;
    measure(lat, len, ld, wd);
    chkEq("R4 offset kept after change", len, LEN_OFS);
    {modeSel1, modeSel2} = 2'b00; calReq = 1'b1;
    tick(4); {modeSel1, modeSel2} = 2'b10; tick(2); calReq = 1'b0;
    measure(lat, len, ld, wd);
    chkEq("R4 self kept after change", len, LEN_SELF);
    chkEq("R4 self no load", int'(ld), 0);

    // R9: polarity change clears calibration
    chkEq("R9 calibrated before change", int'(calibrated), 1);
    bipolarSel = 1'b1; tick(1);
    chkEq("R9 calibrated cleared", int'(calibrated), 0);
    pulseCal(2'b11, 4); measure(lat, len, ld, wd);
    bipolarSel = 1'b0; tick(2);
    pulseCal(2'b01, 4); measure(lat, len, ld, wd);
    chkEq("R9 gain after polarity change rejected", lat, 0);
    pulseCal(2'b10, 4); tick(3);
    tot = 1;
    tick(5); tot += 5; bipolarSel = 1'b1;
    for (int g = 0; g < 200; g++) begin
      tick(1);
      if (!dataReady) begin ld = resultLoad; break; end
      tot++;
    end
    chkEq("R9 spoiled step length", tot, LEN_ONE);
    chkEq("R9 spoiled step load", int'(ld), 1);
    chkEq("R9 spoiled step not calibrated", int'(calibrated), 0);

    // R5: requests released around the end of a running offset step
    for (int k = LEN_OFS - 9; k <= LEN_OFS - 3; k++) begin
      pulseCal(2'b11, 4); tick(3);
      tick(k);
      pulseCal(2'b11, 4);
      rises = 0; prev = dataReady;
      for (int j = 0; j < 3 * LEN_OFS; j++) begin
        tick(1);
        if (dataReady && !prev) rises++;
        prev = dataReady;
      end
      chkEq($sformatf("R5 release at %0d new steps", k + 4), rises,
            (k + 6 >= LEN_OFS) ? 1 : 0);
    end

    // R1 again: reset clears sticky state
    rstN = 1'b0; tick(2); rstN = 1'b1; tick(1);
    chkEq("R1 orderErr after reset", int'(orderErr), 0);
    chkEq("R1 calibrated after reset", int'(calibrated), 0);
    chkEq("R1 word after reset", int'(resultWord), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule